// File: doc/BRIEF.md
# DMA Channel Request and Termination Sequencer

This block runs one DMA channel. It walks a chain of buffer descriptors and moves one bus word per transfer. Each transfer is a read at the source pointer followed by a write at the destination pointer. A small descriptor port supplies each descriptor's valid flag, word count and two pointers. When a descriptor is closed, the block sends back the remaining count and the reason for the close. The chain ends at the first descriptor whose valid flag is clear.

Static mode inputs set the following:
- whether each pointer advances after its bus beat;
- which side is a peripheral, which selects where the acknowledge is driven;
- whether transfers run freely or are paced by an external request line, which can be level- or edge-sensitive;
- how an external terminate input is handled.

On a terminate, the current descriptor is always closed. A mode bit then chooses between two behaviours. The channel can halt until the next start command, or it can fetch the next descriptor and wait for the next request.

The mode inputs are expected to stay stable while the channel is busy. Start and stop are one-cycle command strobes. The request input is asynchronous and is synchronised inside the block. The terminate input is synchronous.

Top module: `dma_seq_ctrl`

## Requirements
- R1: After reset the channel is idle. busy_o, err_o, dack_o, bus_req_o and desc_req_o are all 0.
- R2: The read address advances by DW/8 after each read beat when cfg_src_inc_i is 1. It stays at the descriptor's source pointer when cfg_src_inc_i is 0.
- R3: The write address advances by DW/8 after each write beat when cfg_dst_inc_i is 1. It stays at the descriptor's destination pointer when cfg_dst_inc_i is 0.
- R4: With cfg_ext_req_i = 0, the channel transfers back to back and ignores dreq_i and done_i. It stops only at a descriptor with desc_valid_i = 0 or on a stop command.
- R5: With cfg_ext_req_i = 1 and cfg_req_edge_i = 0, a transfer starts only while the synchronised dreq_i is high.
- R6: With cfg_ext_req_i = 1 and cfg_req_edge_i = 1, each rising edge of the synchronised dreq_i launches exactly one transfer, meaning one read beat and one write beat.
- R7: With cfg_done_resume_i = 0, done_i closes the current descriptor with the terminate flag set and returns the channel to idle. dreq_i then has no effect until start_i.
- R8: With cfg_done_resume_i = 1, done_i closes the current descriptor with the terminate flag set. The channel then fetches the next descriptor and waits for dreq_i.
- R9: cfg_dir_i bit 1 marks the source as a peripheral and bit 0 marks the destination as a peripheral: 00 is memory to memory, 10 is peripheral to memory, 01 is memory to peripheral. dack_o is high exactly during bus beats to or from the peripheral side.
- R10: With cfg_dir_i = 00 and cfg_ext_req_i = 1, done_i has no effect and descriptors close only when their count reaches zero.
- R11: A start_i with cfg_dir_i = 11 sets err_o and leaves the channel idle. A later start_i with a legal cfg_dir_i clears err_o.
- R12: A descriptor close is a one-cycle desc_wb_o pulse. It carries the remaining count in desc_wb_count_o and the reason in desc_wb_by_done_o: 1 for a terminate, 0 when the count reached zero. A descriptor with count 0 closes with no bus beats.
- R13: stop_i while busy lets the current read/write pair finish, then issues no further bus beats and returns the channel to idle without a close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command strobe |
| stop_i | input | 1 | Stop command strobe |
| cfg_src_inc_i | input | 1 | Advance the source pointer after each read |
| cfg_dst_inc_i | input | 1 | Advance the destination pointer after each write |
| cfg_ext_req_i | input | 1 | Pace transfers by dreq_i and honour done_i |
| cfg_done_resume_i | input | 1 | After a terminate: 1 resumes on the next request, 0 halts |
| cfg_req_edge_i | input | 1 | 1 selects edge-sensitive dreq_i, 0 selects level-sensitive |
| cfg_dir_i | input | 2 | Peripheral sides: bit 1 is the source, bit 0 is the destination; 11 is illegal |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_ack_i | input | 1 | Descriptor fields are valid this cycle |
| desc_valid_i | input | 1 | Descriptor valid flag |
| desc_count_i | input | CW | Word count |
| desc_src_i | input | AW | Source pointer |
| desc_dst_i | input | AW | Destination pointer |
| desc_wb_o | output | 1 | Descriptor close pulse |
| desc_wb_count_o | output | CW | Remaining count at close |
| desc_wb_by_done_o | output | 1 | Close caused by terminate |
| bus_req_o | output | 1 | Bus beat request |
| bus_we_o | output | 1 | 1 for a write beat, 0 for a read beat |
| bus_addr_o | output | AW | Byte address of the beat |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data |
| bus_ack_i | input | 1 | Beat complete |
| dreq_i | input | 1 | External transfer request (asynchronous) |
| dack_o | output | 1 | Acknowledge toward the peripheral side |
| done_i | input | 1 | External terminate |
| busy_o | output | 1 | Channel active |
| err_o | output | 1 | Illegal direction was given at the last start |

## Verification
The hardest situation to reach is a terminate that arrives while the channel is part-way through a descriptor and parked waiting for its next request. The close must then report the exact remaining count. After that, either later requests must be ignored or the channel must continue with the next descriptor in the chain. The bench reaches this state by driving an edge-paced chain. It gives a counted number of request pulses, each far enough apart to pass the synchroniser, and then pulses done_i once while the channel sits between transfers. Random memory-to-memory chains with random pointer modes and counts cover the address-stepping paths, with a shadow-memory model supplying the expected contents.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_CLOSE
  } dma_state_e;

  localparam logic [1:0] DIR_M2M = 2'b00;
  localparam logic [1:0] DIR_RSV = 2'b11;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  input  logic edge_mode_i,
  input  logic arm_i,
  input  logic consume_i,
  input  logic clear_i,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic pend_q;
  logic rise;

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], dreq_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      // a new edge wins over a consume in the same cycle
      if (clear_i)            pend_q <= 1'b0;
      else if (rise && arm_i) pend_q <= 1'b1;
      else if (consume_i)     pend_q <= 1'b0;
    end
  end

  assign req_o = edge_mode_i ? pend_q : sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] init_i,
  input  logic          step_i,
  input  logic          inc_en_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_o <= '0;
    else if (load_i)              ptr_o <= init_i;
    else if (step_i && inc_en_i)  ptr_o <= ptr_o + AW'(STEP);
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cfg_src_inc_i,
  input  logic          cfg_dst_inc_i,
  input  logic          cfg_ext_req_i,
  input  logic          cfg_done_resume_i,
  input  logic          cfg_req_edge_i,
  input  logic [1:0]    cfg_dir_i,
  output logic          desc_req_o,
  input  logic          desc_ack_i,
  input  logic          desc_valid_i,
  input  logic [CW-1:0] desc_count_i,
  input  logic [AW-1:0] desc_src_i,
  input  logic [AW-1:0] desc_dst_i,
  output logic          desc_wb_o,
  output logic [CW-1:0] desc_wb_count_o,
  output logic          desc_wb_by_done_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          dreq_i,
  output logic          dack_o,
  input  logic          done_i,
  output logic          busy_o,
  output logic          err_o
);
  localparam int STEP = DW / 8;
  localparam int NSIDE = 2;

  dma_state_e state_q, state_d;
  logic [CW-1:0] count_q;
  logic [DW-1:0] data_q;
  logic by_done_q, stop_pend_q, done_pend_q, err_q;

  logic done_en, done_hit, stop_any, req_seen, req_go;
  logic fetch_load, req_consume, req_clear, enter_close;

  logic [NSIDE-1:0][AW-1:0] ptr_init, ptr_q;
  logic [NSIDE-1:0] ptr_step, ptr_inc;

  // terminate is honoured only when paced and a peripheral side exists
  assign done_en  = cfg_ext_req_i && (cfg_dir_i != DIR_M2M) && (cfg_dir_i != DIR_RSV);
  assign done_hit = done_en && (done_i || done_pend_q);
  assign stop_any = stop_i || stop_pend_q;
  assign req_go   = !cfg_ext_req_i || req_seen;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i && cfg_dir_i != DIR_RSV) state_d = ST_FETCH;
      ST_FETCH: begin
        if (stop_any)        state_d = ST_IDLE;
        else if (desc_ack_i) state_d = desc_valid_i ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        if (stop_any)            state_d = ST_IDLE;
        else if (done_hit)       state_d = ST_CLOSE;
        else if (count_q == '0)  state_d = ST_CLOSE;
        else if (req_go)         state_d = ST_READ;
      end
      ST_READ:  if (bus_ack_i) state_d = ST_WRITE;
      ST_WRITE: begin
        if (bus_ack_i) begin
          if (done_hit || count_q == CW'(1)) state_d = ST_CLOSE;
          else if (stop_any)                  state_d = ST_IDLE;
          else                                state_d = ST_WAIT;
        end
      end
      ST_CLOSE: begin
        if ((by_done_q && !cfg_done_resume_i) || stop_any) state_d = ST_IDLE;
        else                                                state_d = ST_FETCH;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  assign fetch_load  = (state_q == ST_FETCH) && desc_ack_i && !stop_any;
  assign enter_close = (state_d == ST_CLOSE) && (state_q != ST_CLOSE);
  assign req_consume = (state_q == ST_WAIT) && (state_d == ST_READ);
  assign req_clear   = (state_q == ST_IDLE) || (enter_close && done_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      count_q     <= '0;
      data_q      <= '0;
      by_done_q   <= 1'b0;
      stop_pend_q <= 1'b0;
      done_pend_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) err_q <= (cfg_dir_i == DIR_RSV);
      if (fetch_load) count_q <= desc_count_i;
      else if (state_q == ST_WRITE && bus_ack_i) count_q <= count_q - CW'(1);
      if (state_q == ST_READ && bus_ack_i) data_q <= bus_rdata_i;
      if (enter_close) by_done_q <= done_hit;
      if (state_q == ST_IDLE) stop_pend_q <= 1'b0;
      else if (stop_i)        stop_pend_q <= 1'b1;
      if (state_d == ST_CLOSE || state_d == ST_IDLE) done_pend_q <= 1'b0;
      else if (state_q != ST_IDLE && done_en && done_i) done_pend_q <= 1'b1;
    end
  end

  dma_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dreq_i      (dreq_i),
    .edge_mode_i (cfg_req_edge_i),
    .arm_i       (state_q != ST_IDLE),
    .consume_i   (req_consume),
    .clear_i     (req_clear),
    .req_o       (req_seen)
  );

  assign ptr_init[0] = desc_src_i;
  assign ptr_init[1] = desc_dst_i;
  assign ptr_step[0] = (state_q == ST_READ)  && bus_ack_i;
  assign ptr_step[1] = (state_q == ST_WRITE) && bus_ack_i;
  assign ptr_inc     = {cfg_dst_inc_i, cfg_src_inc_i};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_ptr_unit #(.AW(AW), .STEP(STEP)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (fetch_load),
      .init_i   (ptr_init[g]),
      .step_i   (ptr_step[g]),
      .inc_en_i (ptr_inc[g]),
      .ptr_o    (ptr_q[g])
    );
  end

  assign desc_req_o        = (state_q == ST_FETCH);
  assign bus_req_o         = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign bus_we_o          = (state_q == ST_WRITE);
  assign bus_addr_o        = bus_we_o ? ptr_q[1] : ptr_q[0];
  assign bus_wdata_o       = data_q;
  assign dack_o            = ((state_q == ST_READ) && cfg_dir_i[1]) ||
                             ((state_q == ST_WRITE) && cfg_dir_i[0]);
  assign desc_wb_o         = (state_q == ST_CLOSE);
  assign desc_wb_count_o   = count_q;
  assign desc_wb_by_done_o = by_done_q;
  assign busy_o            = (state_q != ST_IDLE);
  assign err_o             = err_q;
endmodule

// File: rtl/dma_seq_ctrl_chk.sv
module dma_seq_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          cfg_ext_req_i,
  input logic          cfg_done_resume_i,
  input logic [1:0]    cfg_dir_i,
  input logic          desc_req_o,
  input logic          desc_wb_o,
  input logic          desc_wb_by_done_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_ack_i,
  input logic          dack_o,
  input logic          busy_o,
  input logic          err_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_req_o && !desc_req_o && !dack_o));

  a_r2_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  a_r4_no_done_free_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wb_o && !cfg_ext_req_i) |-> !desc_wb_by_done_o);

  a_r7_halt_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wb_o && desc_wb_by_done_o && !cfg_done_resume_i) |=> !busy_o);

  a_r9_dack_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (bus_req_o && (bus_we_o ? cfg_dir_i[0] : cfg_dir_i[1])));

  a_r10_m2m_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_wb_o && cfg_dir_i == 2'b00) |-> !desc_wb_by_done_o);

  a_r11_reserved_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && cfg_dir_i == 2'b11) |=> (!busy_o && err_o));

  a_r12_wb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_wb_o |=> !desc_wb_o);
endmodule

bind dma_seq_ctrl dma_seq_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .start_i           (start_i),
  .cfg_ext_req_i     (cfg_ext_req_i),
  .cfg_done_resume_i (cfg_done_resume_i),
  .cfg_dir_i         (cfg_dir_i),
  .desc_req_o        (desc_req_o),
  .desc_wb_o         (desc_wb_o),
  .desc_wb_by_done_o (desc_wb_by_done_o),
  .bus_req_o         (bus_req_o),
  .bus_we_o          (bus_we_o),
  .bus_addr_o        (bus_addr_o),
  .bus_ack_i         (bus_ack_i),
  .dack_o            (dack_o),
  .busy_o            (busy_o),
  .err_o             (err_o)
);

// File: tb/dma_seq_ctrl_bench.sv
module dma_seq_ctrl_bench;
  localparam int AW = 32, DW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic sinc = 1'b1, dinc = 1'b1, ext_req = 1'b0, resume = 1'b0, edge_md = 1'b0;
  logic [1:0] dir = 2'b00;
  logic desc_req, desc_ack = 1'b0, desc_valid = 1'b0;
  logic [CW-1:0] desc_count = '0;
  logic [AW-1:0] desc_src = '0, desc_dst = '0;
  logic wb, wb_bd;
  logic [CW-1:0] wb_count;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic dreq = 1'b0, dack, done = 1'b0, busy, err;

  always #2 clk = ~clk;

  dma_seq_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_dma_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .cfg_src_inc_i(sinc), .cfg_dst_inc_i(dinc), .cfg_ext_req_i(ext_req),
    .cfg_done_resume_i(resume), .cfg_req_edge_i(edge_md), .cfg_dir_i(dir),
    .desc_req_o(desc_req), .desc_ack_i(desc_ack), .desc_valid_i(desc_valid),
    .desc_count_i(desc_count), .desc_src_i(desc_src), .desc_dst_i(desc_dst),
    .desc_wb_o(wb), .desc_wb_count_o(wb_count), .desc_wb_by_done_o(wb_bd),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack),
    .dreq_i(dreq), .dack_o(dack), .done_i(done), .busy_o(busy), .err_o(err)
  );

  logic [31:0] mem [256];
  logic [31:0] refm [256];
  logic        t_valid [8];
  logic [CW-1:0] t_count [8];
  logic [AW-1:0] t_src [8];
  logic [AW-1:0] t_dst [8];
  int didx, wb_n, rd_n, wr_n, dack_rd, dack_wr;
  logic [CW-1:0] wb_cnt [16];
  logic wb_flag [16];
  logic [AW-1:0] rd_log [64];
  logic [AW-1:0] wr_log [64];
  int total = 0, bad = 0;

  // bus, descriptor and writeback responder
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      desc_ack = 1'b0;
    end else begin
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        bus_ack = 1'b1;
        if (bus_we) begin
          mem[bus_addr[9:2]] = bus_wdata;
          wr_log[wr_n[5:0]] = bus_addr;
          wr_n++;
          if (dack) dack_wr++;
        end else begin
          bus_rdata = mem[bus_addr[9:2]];
          rd_log[rd_n[5:0]] = bus_addr;
          rd_n++;
          if (dack) dack_rd++;
        end
      end
      if (desc_ack) desc_ack = 1'b0;
      else if (desc_req) begin
        desc_ack = 1'b1;
        desc_valid = (didx < 8) ? t_valid[didx] : 1'b0;
        desc_count = (didx < 8) ? t_count[didx] : '0;
        desc_src   = (didx < 8) ? t_src[didx] : '0;
        desc_dst   = (didx < 8) ? t_dst[didx] : '0;
        didx++;
      end
      if (wb) begin
        wb_cnt[wb_n[3:0]] = wb_count;
        wb_flag[wb_n[3:0]] = wb_bd;
        wb_n++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < 8; i++) begin
      t_valid[i] = 1'b0; t_count[i] = '0; t_src[i] = '0; t_dst[i] = '0;
    end
    didx = 0; wb_n = 0; rd_n = 0; wr_n = 0; dack_rd = 0; dack_wr = 0;
  endtask

  task automatic set_desc(input int i, input int cnt, input int s, input int d);
    t_valid[i] = 1'b1; t_count[i] = CW'(cnt); t_src[i] = AW'(s); t_dst[i] = AW'(d);
  endtask

  task automatic pulse_start();
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic pulse_dreq();
    dreq = 1'b1; tick(4); dreq = 1'b0; tick(12);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 3000 && busy; n++) tick(1);
  endtask

  // expected memory for a memory-to-memory chain from the descriptor table
  task automatic model_chain();
    for (int i = 0; i < 8 && t_valid[i]; i++) begin
      logic [AW-1:0] s, d;
      s = t_src[i]; d = t_dst[i];
      for (int c = 0; c < int'(t_count[i]); c++) begin
        refm[d[9:2]] = refm[s[9:2]];
        if (sinc) s = s + 4;
        if (dinc) d = d + 4;
      end
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) n++;
    return n;
  endfunction

  task automatic sync_ref();
    for (int i = 0; i < 256; i++) refm[i] = mem[i];
  endtask

  initial begin
    int seed, nd;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    clear_all();
    tick(3);
    // R1 reset state
    chk(!busy && !err && !dack && !bus_req && !desc_req, "R1 reset outputs",
        {busy, err, dack, bus_req, desc_req}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!busy && !bus_req, "R1 idle after reset", busy, 0);

    // R11 reserved direction
    dir = 2'b11; pulse_start(); tick(5);
    chk(err == 1'b1, "R11 err on reserved dir", err, 1);
    chk(!busy && didx == 0, "R11 no start on reserved dir", didx, 0);
    dir = 2'b00; pulse_start(); wait_idle(); tick(2);
    chk(err == 1'b0, "R11 err cleared by legal start", err, 0);

    // R4 R12 free-running chain, dreq low and done high ignored
    clear_all(); sync_ref();
    sinc = 1; dinc = 1; ext_req = 0; dir = 2'b00; done = 1'b1;
    set_desc(0, 3, 32'h010, 32'h240);
    set_desc(1, 0, 32'h020, 32'h260);
    set_desc(2, 2, 32'h030, 32'h280);
    model_chain();
    pulse_start(); wait_idle(); tick(2); done = 1'b0;
    chk(wr_n == 5, "R4 free-run write beats", wr_n, 5);
    chk(mem_diff() == 0, "R4 chain copy", mem_diff(), 0);
    chk(wb_n == 3, "R12 close count", wb_n, 3);
    chk(wb_cnt[1] == 0 && wb_flag[1] == 0, "R12 zero-count close", wb_cnt[1], 0);
    chk(wb_flag[0] == 0 && wb_flag[2] == 0, "R4 done ignored in free run", wb_flag[0], 0);

    // R2 R3 random chains
    for (int it = 0; it < 8; it++) begin
      clear_all(); sync_ref();
      sinc = $urandom % 2; dinc = $urandom % 2;
      nd = 1 + $urandom % 3;
      for (int k = 0; k < nd; k++)
        set_desc(k, 1 + $urandom % 6, ($urandom % 64) * 4, 512 + ($urandom % 64) * 4);
      model_chain();
      pulse_start(); wait_idle(); tick(2);
      chk(mem_diff() == 0, "R2 R3 random chain contents", mem_diff(), 0);
      chk(wb_n == nd && wb_cnt[0] == 0, "R12 random closes", wb_n, nd);
    end

    // R5 level pacing, peripheral to memory
    clear_all();
    sinc = 0; dinc = 1; ext_req = 1; edge_md = 0; dir = 2'b10; resume = 0;
    set_desc(0, 3, 32'h080, 32'h300);
    pulse_start(); tick(20);
    chk(rd_n == 0 && busy, "R5 no transfer while dreq low", rd_n, 0);
    dreq = 1'b1; wait_idle(); dreq = 1'b0; tick(2);
    chk(rd_n == 3 && wr_n == 3, "R5 transfers while dreq high", rd_n, 3);
    chk(rd_log[0] == 32'h080 && rd_log[2] == 32'h080, "R2 fixed source", rd_log[2], 32'h080);
    chk(wr_log[2] == 32'h308, "R3 stepping destination", wr_log[2], 32'h308);
    chk(dack_rd == 3 && dack_wr == 0, "R9 dack on peripheral reads", dack_rd, 3);

    // R6 R7 edge pacing and halting terminate, memory to peripheral
    clear_all();
    sinc = 1; dinc = 0; edge_md = 1; dir = 2'b01; resume = 0;
    set_desc(0, 5, 32'h040, 32'h3F0);
    set_desc(1, 2, 32'h060, 32'h3F0);
    pulse_start(); tick(6);
    pulse_dreq();
    chk(wr_n == 1, "R6 one edge one transfer", wr_n, 1);
    pulse_dreq();
    chk(wr_n == 2, "R6 second edge second transfer", wr_n, 2);
    done = 1'b1; tick(1); done = 1'b0; tick(5);
    chk(wb_n == 1 && wb_flag[0] == 1, "R7 terminate close flag", wb_flag[0], 1);
    chk(wb_cnt[0] == 3, "R7 remaining count", wb_cnt[0], 3);
    chk(!busy, "R7 idle after terminate", busy, 0);
    pulse_dreq();
    chk(wr_n == 2, "R7 dreq ignored after halt", wr_n, 2);
    pulse_start(); tick(6);
    pulse_dreq(); pulse_dreq(); wait_idle(); tick(2);
    chk(wr_n == 4 && wb_n == 2 && wb_flag[1] == 0, "R7 restart continues chain", wr_n, 4);
    chk(rd_log[1] == 32'h044 && rd_log[3] == 32'h064, "R2 stepping source", rd_log[3], 32'h064);
    chk(wr_log[0] == 32'h3F0 && wr_log[3] == 32'h3F0, "R3 fixed destination", wr_log[3], 32'h3F0);
    chk(dack_wr == 4 && dack_rd == 0, "R9 dack on peripheral writes", dack_wr, 4);

    // R8 resuming terminate
    clear_all();
    sinc = 0; dinc = 1; dir = 2'b10; resume = 1;
    set_desc(0, 4, 32'h080, 32'h280);
    set_desc(1, 1, 32'h080, 32'h2C0);
    pulse_start(); tick(6);
    pulse_dreq();
    done = 1'b1; tick(1); done = 1'b0; tick(10);
    chk(wb_n == 1 && wb_flag[0] == 1 && wb_cnt[0] == 3, "R8 terminate close", wb_cnt[0], 3);
    chk(busy && didx == 2 && rd_n == 1, "R8 next fetched and waiting", didx, 2);
    pulse_dreq(); wait_idle(); tick(2);
    chk(rd_n == 2 && wr_log[1] == 32'h2C0, "R8 resumes on next dreq", wr_log[1], 32'h2C0);

    // R10 memory to memory, paced, terminate ignored
    clear_all(); sync_ref();
    sinc = 1; dinc = 1; edge_md = 0; dir = 2'b00; resume = 0;
    set_desc(0, 4, 32'h100, 32'h380);
    model_chain();
    dreq = 1'b1; done = 1'b1;
    pulse_start(); wait_idle(); tick(2);
    dreq = 1'b0; done = 1'b0;
    chk(wb_n == 1 && wb_flag[0] == 0 && wb_cnt[0] == 0, "R10 done ignored in m2m", wb_flag[0], 0);
    chk(mem_diff() == 0 && dack_rd + dack_wr == 0, "R10 R9 m2m copy no dack", dack_rd + dack_wr, 0);

    // R13 stop
    clear_all();
    ext_req = 0;
    set_desc(0, 40, 32'h000, 32'h200);
    pulse_start(); tick(10);
    stop = 1'b1; tick(1); stop = 1'b0; tick(10);
    chk(!busy && wr_n > 0 && wr_n < 40, "R13 stop halts", wr_n, 40);
    chk(wb_n == 0 && rd_n == wr_n, "R13 no close, pair finished", rd_n, wr_n);
    nd = wr_n; tick(20);
    chk(wr_n == nd, "R13 no beats after stop", wr_n, nd);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule